// File: doc/BRIEF.md
# Copy Engine Register Front End

This block is the memory-mapped register decoder that sits in front of a multi-channel memory copy engine. A host issues single read or write requests carrying a byte address, an access size and write data. The block splits the address into a global area and a row of per-channel windows. It applies the register side effects, returns read data or an error one cycle later, and passes command writes on to the copy datapath as a one-cycle pulse tagged with the channel number.

The global area holds a read-only channel count, a read-only transfer-capability exponent, an interrupt control byte and an attention status word. Each channel window holds a control halfword, a read-only status doubleword supplied by the datapath, a chain address and a completion address (each 64 bits wide and reachable as two 32-bit halves or as one doubleword), a self-clearing command byte, and an error word. The datapath can raise bits in the attention and error registers through set inputs.

Top module: `ce_mmio_regs`

## Requirements
- R1: The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. An address below 0x80 selects the global area. Any other address selects channel floor(addr/0x80)-1, and addr mod 0x80 is the offset within that channel's window. Selecting a channel at or above NCH is an error.
- R2: Global offset 0x00 (size 1) reads NCH. Offset 0x01 (size 1) reads the bit index of the highest set bit of XFER_MAX. Writes to both are accepted and change nothing.
- R3: Global offset 0x02 (size 1) holds the master interrupt enable in bit 0, which drives intr_en. A write loads it from wdata bit 0. A read returns it and then clears it. It resets to 0.
- R4: Global offset 0x04 (size 4) is attention status. It ORs in attn_set every cycle. A read returns the value and leaves only the bits being set in that same cycle. Writes are ignored.
- R5: Channel offset 0x00 (size 2) is control and resets to 0x0001. A read returns it and then sets bit 1 (in use). A write replaces all bits except bit 0 (interrupt disable): writing 1 to bit 0 clears that bit, and writing 0 keeps its old value.
- R6: Channel offset 0x08 (size 8) reads that channel's 64-bit slice of chan_status. Writes are ignored.
- R7: The chain address sits at channel offset 0x10 (size 4 or 8) and 0x14 (size 4). A size-8 access at 0x10 reads or replaces all 64 bits. A size-4 access at 0x10 reads or replaces bits 31:0 and keeps bits 63:32. An access at 0x14 reads or replaces bits 63:32 and keeps bits 31:0. It resets to 0.
- R8: The completion address follows the rules of R7 at channel offsets 0x20 and 0x24.
- R9: A write to channel offset 0x18 (size 1) pulses cmd_valid with cmd_chan set to the channel and cmd_code set to wdata[7:0]. A read there returns 0.
- R10: Channel offset 0x28 (size 4) is the error word. A write clears each bit written as 1. Bits in that channel's slice of chan_err_set are set every cycle and win over a clear in the same cycle.
- R11: An unmapped offset, or a size other than the one listed for the register, gives a response with rsp_err high for that one response and rsp_rdata zero. Such an access changes no state and fires no command.
- R12: Every request cycle gives exactly one response cycle (rsp_valid high) on the next clock. Read data is the value before the access's own side effect. Write responses carry zero data. After reset, rsp_valid, rsp_err, cmd_valid and intr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Write data, right aligned |
| attn_set | input | 32 | Attention bits to set |
| chan_status | input | NCH*64 | Per-channel status words |
| chan_err_set | input | NCH*32 | Per-channel error bits to set |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access was refused |
| rsp_rdata | output | 64 | Read data, right aligned |
| cmd_valid | output | 1 | Command pulse |
| cmd_chan | output | CH_W | Channel of the command |
| cmd_code | output | 8 | Command byte |
| intr_en | output | 1 | Master interrupt enable |

## Verification
The bench uses two channels and a 10-bit address. It first runs directed sequences that separate the side effects from one another: clear-on-read against sticky state, half-word address writes against full-word ones, write-1-to-clear against a same-cycle set, and interrupt-disable keep against clear. It then sweeps every address in the space with all four size codes, first as writes with address-derived data and then as reads. This exposes any offset, size or channel-window confusion, including the windows above the channel count. Expected data, errors and command pulses come from an arithmetic model of the register rules in the bench.

// File: rtl/ce_mmio_pkg.sv
package ce_mmio_pkg;

  localparam int unsigned WIN_LSB = 7;

  localparam int unsigned CTRL_IDIS_BIT  = 0;
  localparam int unsigned CTRL_INUSE_BIT = 1;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    G_NONE, G_COUNT, G_XCAP, G_INTR, G_ATTN
  } glob_reg_e;

  typedef enum logic [3:0] {
    C_NONE, C_CTRL, C_STAT, C_CHAIN_LO, C_CHAIN_HI,
    C_CMD, C_CMPL_LO, C_CMPL_HI, C_ERR
  } chan_reg_e;

  function automatic glob_reg_e glob_decode(input logic [6:0] off, input acc_size_e sz);
    glob_reg_e r;
    r = G_NONE;
    case (off)
      7'h00: if (sz == SZ_B) r = G_COUNT;
      7'h01: if (sz == SZ_B) r = G_XCAP;
      7'h02: if (sz == SZ_B) r = G_INTR;
      7'h04: if (sz == SZ_W) r = G_ATTN;
      default: r = G_NONE;
    endcase
    return r;
  endfunction

  function automatic chan_reg_e chan_decode(input logic [6:0] off, input acc_size_e sz);
    chan_reg_e r;
    r = C_NONE;
    case (off)
      7'h00: if (sz == SZ_H) r = C_CTRL;
      7'h08: if (sz == SZ_D) r = C_STAT;
      7'h10: if (sz == SZ_W || sz == SZ_D) r = C_CHAIN_LO;
      7'h14: if (sz == SZ_W) r = C_CHAIN_HI;
      7'h18: if (sz == SZ_B) r = C_CMD;
      7'h20: if (sz == SZ_W || sz == SZ_D) r = C_CMPL_LO;
      7'h24: if (sz == SZ_W) r = C_CMPL_HI;
      7'h28: if (sz == SZ_W) r = C_ERR;
      default: r = C_NONE;
    endcase
    return r;
  endfunction

  function automatic int unsigned msb_index(input longint unsigned v);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/ce_mmio_dec.sv
module ce_mmio_dec
  import ce_mmio_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned CH_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              is_glob,
  output glob_reg_e         greg,
  output chan_reg_e         creg,
  output logic [NCH-1:0]    chan_sel,
  output logic [CH_W-1:0]   chan_idx,
  output logic              hit
);

  localparam int unsigned WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] chan_num;
  logic [6:0]       off;
  logic             chan_ok;
  acc_size_e        sz;

  assign win      = addr[ADDR_W-1:WIN_LSB];
  assign off      = addr[WIN_LSB-1:0];
  assign sz       = acc_size_e'(size);
  assign is_glob  = (win == '0);
  assign chan_num = win - WIN_W'(1);
  assign chan_ok  = !is_glob && (32'(chan_num) < 32'(NCH));

  assign greg = is_glob ? glob_decode(off, sz) : G_NONE;
  assign creg = chan_ok ? chan_decode(off, sz) : C_NONE;
  assign hit  = (greg != G_NONE) || (creg != C_NONE);

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign chan_sel[g] = chan_ok && (chan_num == WIN_W'(g));
  end

  always_comb begin
    chan_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chan_sel[i]) chan_idx = CH_W'(i);
    end
  end

endmodule

// File: rtl/ce_glob_regs.sv
module ce_glob_regs
  import ce_mmio_pkg::*;
#(
  parameter int unsigned     NCH      = 4,
  parameter longint unsigned XFER_MAX = 64'd1048576
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        wr,
  input  glob_reg_e   greg,
  input  logic        wbit0,
  input  logic [31:0] attn_set,
  output logic [63:0] rdata,
  output logic        intr_en
);

  localparam int unsigned XCAP = msb_index(XFER_MAX);

  logic        intr_q, intr_d, intr_ce;
  logic [31:0] attn_q, attn_d;
  logic        attn_ce;

  always_comb begin
    intr_d  = intr_q;
    attn_d  = attn_q | attn_set;
    intr_ce = 1'b0;
    attn_ce = |attn_set;
    if (acc_en) begin
      case (greg)
        G_INTR: begin
          intr_ce = 1'b1;
          intr_d  = wr ? wbit0 : 1'b0;
        end
        G_ATTN: if (!wr) begin
          attn_ce = 1'b1;
          attn_d  = attn_set;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_q <= 1'b0;
      attn_q <= '0;
    end else begin
      if (intr_ce) intr_q <= intr_d;
      if (attn_ce) attn_q <= attn_d;
    end
  end

  always_comb begin
    case (greg)
      G_COUNT: rdata = 64'(NCH);
      G_XCAP:  rdata = 64'(XCAP);
      G_INTR:  rdata = {63'd0, intr_q};
      G_ATTN:  rdata = {32'd0, attn_q};
      default: rdata = '0;
    endcase
  end

  assign intr_en = intr_q;

endmodule

// File: rtl/ce_chan_regs.sv
module ce_chan_regs
  import ce_mmio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        wr,
  input  chan_reg_e   creg,
  input  logic [1:0]  size,
  input  logic [63:0] wdata,
  input  logic [63:0] status,
  input  logic [31:0] err_set,
  output logic [63:0] rdata,
  output logic        cmd_fire
);

  localparam logic [15:0] CTRL_RST = 16'(1 << CTRL_IDIS_BIT);

  logic [15:0] ctrl_q, ctrl_d;
  logic [63:0] chain_q, chain_d;
  logic [63:0] cmpl_q, cmpl_d;
  logic [31:0] err_q, err_d;
  logic        ctrl_ce, chain_ce, cmpl_ce, err_ce;
  logic        full;

  assign full = (acc_size_e'(size) == SZ_D);

  always_comb begin
    ctrl_d   = ctrl_q;
    chain_d  = chain_q;
    cmpl_d   = cmpl_q;
    err_d    = err_q | err_set;
    ctrl_ce  = 1'b0;
    chain_ce = 1'b0;
    cmpl_ce  = 1'b0;
    err_ce   = |err_set;
    if (acc_en) begin
      case (creg)
        C_CTRL: begin
          ctrl_ce = 1'b1;
          if (wr) begin
            ctrl_d = wdata[15:0];
            ctrl_d[CTRL_IDIS_BIT] = wdata[CTRL_IDIS_BIT] ? 1'b0 : ctrl_q[CTRL_IDIS_BIT];
          end else begin
            ctrl_d[CTRL_INUSE_BIT] = 1'b1;
          end
        end
        C_CHAIN_LO: if (wr) begin
          chain_ce = 1'b1;
          chain_d  = full ? wdata : {chain_q[63:32], wdata[31:0]};
        end
        C_CHAIN_HI: if (wr) begin
          chain_ce = 1'b1;
          chain_d  = {wdata[31:0], chain_q[31:0]};
        end
        C_CMPL_LO: if (wr) begin
          cmpl_ce = 1'b1;
          cmpl_d  = full ? wdata : {cmpl_q[63:32], wdata[31:0]};
        end
        C_CMPL_HI: if (wr) begin
          cmpl_ce = 1'b1;
          cmpl_d  = {wdata[31:0], cmpl_q[31:0]};
        end
        C_ERR: if (wr) begin
          err_ce = 1'b1;
          err_d  = (err_q & ~wdata[31:0]) | err_set;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      chain_q <= '0;
      cmpl_q  <= '0;
      err_q   <= '0;
    end else begin
      if (ctrl_ce)  ctrl_q  <= ctrl_d;
      if (chain_ce) chain_q <= chain_d;
      if (cmpl_ce)  cmpl_q  <= cmpl_d;
      if (err_ce)   err_q   <= err_d;
    end
  end

  always_comb begin
    case (creg)
      C_CTRL:     rdata = {48'd0, ctrl_q};
      C_STAT:     rdata = status;
      C_CHAIN_LO: rdata = full ? chain_q : {32'd0, chain_q[31:0]};
      C_CHAIN_HI: rdata = {32'd0, chain_q[63:32]};
      C_CMPL_LO:  rdata = full ? cmpl_q : {32'd0, cmpl_q[31:0]};
      C_CMPL_HI:  rdata = {32'd0, cmpl_q[63:32]};
      C_ERR:      rdata = {32'd0, err_q};
      default:    rdata = '0;
    endcase
  end

  assign cmd_fire = acc_en && wr && (creg == C_CMD);

endmodule

// File: rtl/ce_mmio_regs.sv
module ce_mmio_regs
  import ce_mmio_pkg::*;
#(
  parameter int unsigned     NCH      = 4,
  parameter int unsigned     ADDR_W   = 14,
  parameter longint unsigned XFER_MAX = 64'd1048576,
  localparam int unsigned    CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [31:0]       attn_set,
  input  logic [NCH*64-1:0] chan_status,
  input  logic [NCH*32-1:0] chan_err_set,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic              cmd_valid,
  output logic [CH_W-1:0]   cmd_chan,
  output logic [7:0]        cmd_code,
  output logic              intr_en
);

  logic            dec_glob, dec_hit, acc_ok;
  glob_reg_e       dec_greg;
  chan_reg_e       dec_creg;
  logic [NCH-1:0]  dec_sel;
  logic [CH_W-1:0] dec_idx;
  logic [63:0]     glob_rd;
  logic [63:0]     ch_rd [NCH];
  logic [NCH-1:0]  ch_cmd;

  ce_mmio_dec #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .addr(req_addr), .size(req_size), .is_glob(dec_glob), .greg(dec_greg),
    .creg(dec_creg), .chan_sel(dec_sel), .chan_idx(dec_idx), .hit(dec_hit)
  );

  assign acc_ok = req_valid && dec_hit;

  ce_glob_regs #(.NCH(NCH), .XFER_MAX(XFER_MAX)) u_glob (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_ok && dec_glob), .wr(req_write),
    .greg(dec_greg), .wbit0(req_wdata[0]), .attn_set(attn_set),
    .rdata(glob_rd), .intr_en(intr_en)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    ce_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_ok && dec_sel[g]), .wr(req_write),
      .creg(dec_creg), .size(req_size), .wdata(req_wdata),
      .status(chan_status[g*64 +: 64]), .err_set(chan_err_set[g*32 +: 32]),
      .rdata(ch_rd[g]), .cmd_fire(ch_cmd[g])
    );
  end

  // response next state
  logic [63:0] rd_mux;
  logic        rsp_valid_d, rsp_err_d, cmd_valid_d;
  logic [63:0] rsp_rdata_d;

  always_comb begin
    rd_mux = dec_glob ? glob_rd : '0;
    for (int i = 0; i < NCH; i++) begin
      if (dec_sel[i]) rd_mux = rd_mux | ch_rd[i];
    end
    rsp_valid_d = req_valid;
    rsp_err_d   = req_valid && !dec_hit;
    rsp_rdata_d = (acc_ok && !req_write) ? rd_mux : '0;
    cmd_valid_d = |ch_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      cmd_valid <= 1'b0;
      cmd_chan  <= '0;
      cmd_code  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      cmd_valid <= cmd_valid_d;
      if (req_valid) begin
        rsp_rdata <= rsp_rdata_d;
        cmd_chan  <= dec_idx;
        cmd_code  <= req_wdata[7:0];
      end
    end
  end

endmodule

// File: rtl/ce_mmio_regs_chk.sv
module ce_mmio_regs_chk #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [63:0]     rsp_rdata,
  input logic            cmd_valid,
  input logic [CH_W-1:0] cmd_chan,
  input logic            intr_en
);

  a_r12_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r11_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 64'd0));

  a_r9_cmd_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(req_valid) && $past(req_write)));

  a_r9_cmd_ok_chan: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (rsp_valid && !rsp_err && 32'(cmd_chan) < 32'(NCH)));

  a_r3_intr_drop_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intr_en) |-> $past(req_valid));

endmodule

bind ce_mmio_regs ce_mmio_regs_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .intr_en(intr_en)
);

// File: tb/ce_mmio_regs_tb.sv
module ce_mmio_regs_tb_top;

  localparam int unsigned     NCH      = 2;
  localparam int unsigned     ADDR_W   = 10;
  localparam longint unsigned XFER_MAX = 64'd4096;
  localparam int unsigned     CH_W     = 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic [63:0]       req_wdata;
  logic [31:0]       attn_set;
  logic [NCH*64-1:0] chan_status;
  logic [NCH*32-1:0] chan_err_set;
  logic              rsp_valid, rsp_err, cmd_valid, intr_en;
  logic [63:0]       rsp_rdata;
  logic [CH_W-1:0]   cmd_chan;
  logic [7:0]        cmd_code;

  always #2 clk = ~clk;

  ce_mmio_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .XFER_MAX(XFER_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .attn_set(attn_set), .chan_status(chan_status), .chan_err_set(chan_err_set),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_code(cmd_code),
    .intr_en(intr_en)
  );

  function automatic logic [63:0] stat_val(input int c);
    return 64'h5AC0_0000_0000_1000 + 64'(c) * 64'h0101_0000_0000_0011;
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_st
    assign chan_status[g*64 +: 64] = stat_val(g);
  end

  function automatic int exp_xcap();
    int r;
    r = 0;
    for (int i = 0; i < 64; i++) if (XFER_MAX[i]) r = i;
    return r;
  endfunction

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model of the registers
  logic        m_intr;
  logic [31:0] m_attn;
  logic [15:0] m_ctrl  [NCH];
  logic [63:0] m_chain [NCH];
  logic [63:0] m_cmpl  [NCH];
  logic [31:0] m_err   [NCH];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int addr, input int sz, input logic [63:0] wd);
    int win, off, ch;
    bit e_err, e_cmd;
    logic [63:0] e_rd;
    logic keep;
    string tag;
    win = addr / 128; off = addr % 128; ch = win - 1;
    e_err = 1; e_cmd = 0; e_rd = '0; tag = "R11";
    if (win == 0) begin
      if (off == 0 && sz == 0) begin e_err = 0; tag = "R2"; if (!wr) e_rd = 64'(NCH); end
      else if (off == 1 && sz == 0) begin e_err = 0; tag = "R2"; if (!wr) e_rd = 64'(exp_xcap()); end
      else if (off == 2 && sz == 0) begin
        e_err = 0; tag = "R3";
        if (wr) m_intr = wd[0]; else begin e_rd = {63'd0, m_intr}; m_intr = 0; end
      end else if (off == 4 && sz == 2) begin
        e_err = 0; tag = "R4";
        if (!wr) begin e_rd = {32'd0, m_attn}; m_attn = 0; end
      end
    end else if (ch >= NCH) begin
      tag = "R1";
    end else begin
      if (off == 'h00 && sz == 1) begin
        e_err = 0; tag = "R5";
        if (wr) begin keep = m_ctrl[ch][0]; m_ctrl[ch] = wd[15:0]; m_ctrl[ch][0] = wd[0] ? 1'b0 : keep; end
        else begin e_rd = {48'd0, m_ctrl[ch]}; m_ctrl[ch][1] = 1'b1; end
      end else if (off == 'h08 && sz == 3) begin
        e_err = 0; tag = "R6"; if (!wr) e_rd = stat_val(ch);
      end else if (off == 'h10 && (sz == 2 || sz == 3)) begin
        e_err = 0; tag = "R7";
        if (wr) begin if (sz == 3) m_chain[ch] = wd; else m_chain[ch][31:0] = wd[31:0]; end
        else e_rd = (sz == 3) ? m_chain[ch] : {32'd0, m_chain[ch][31:0]};
      end else if (off == 'h14 && sz == 2) begin
        e_err = 0; tag = "R7";
        if (wr) m_chain[ch][63:32] = wd[31:0]; else e_rd = {32'd0, m_chain[ch][63:32]};
      end else if (off == 'h18 && sz == 0) begin
        e_err = 0; tag = "R9"; if (wr) e_cmd = 1;
      end else if (off == 'h20 && (sz == 2 || sz == 3)) begin
        e_err = 0; tag = "R8";
        if (wr) begin if (sz == 3) m_cmpl[ch] = wd; else m_cmpl[ch][31:0] = wd[31:0]; end
        else e_rd = (sz == 3) ? m_cmpl[ch] : {32'd0, m_cmpl[ch][31:0]};
      end else if (off == 'h24 && sz == 2) begin
        e_err = 0; tag = "R8";
        if (wr) m_cmpl[ch][63:32] = wd[31:0]; else e_rd = {32'd0, m_cmpl[ch][63:32]};
      end else if (off == 'h28 && sz == 2) begin
        e_err = 0; tag = "R10";
        if (wr) m_err[ch] = m_err[ch] & ~wd[31:0]; else e_rd = {32'd0, m_err[ch]};
      end
    end
    req_valid = 1; req_write = wr; req_addr = ADDR_W'(addr); req_size = 2'(sz); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R12", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_err === e_err, tag, $sformatf("err @%0h sz%0d", addr, sz), 64'(rsp_err), 64'(e_err));
    chk(rsp_rdata === e_rd, tag, $sformatf("data @%0h sz%0d", addr, sz), rsp_rdata, e_rd);
    chk(cmd_valid === e_cmd, "R9", "cmd_valid", 64'(cmd_valid), 64'(e_cmd));
    if (e_cmd) chk(cmd_chan === CH_W'(ch) && cmd_code === wd[7:0], "R9", "cmd chan/code",
                   {55'd0, cmd_chan, cmd_code}, {55'd0, CH_W'(ch), wd[7:0]});
    chk(intr_en === m_intr, "R3", "intr_en", 64'(intr_en), 64'(m_intr));
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    chk(rsp_valid === 1'b0 && cmd_valid === 1'b0, "R12", "idle rsp/cmd",
        {62'd0, rsp_valid, cmd_valid}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_size = '0;
    req_wdata = '0; attn_set = '0; chan_err_set = '0;
    m_intr = 0; m_attn = 0;
    for (int c = 0; c < NCH; c++) begin
      m_ctrl[c] = 16'h0001; m_chain[c] = '0; m_cmpl[c] = '0; m_err[c] = '0;
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(rsp_valid === 0 && rsp_err === 0 && cmd_valid === 0 && intr_en === 0, "R12",
        "reset outputs", {60'd0, rsp_valid, rsp_err, cmd_valid, intr_en}, 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R2 constants, write ignored
    access(0, 'h00, 0, 0); access(0, 'h01, 0, 0);
    access(1, 'h00, 0, 64'hFF); access(1, 'h01, 0, 64'hFF);
    access(0, 'h00, 0, 0); access(0, 'h01, 0, 0);
    // R3 interrupt enable cleared by read
    access(1, 'h02, 0, 64'h1); access(0, 'h02, 0, 0); access(0, 'h02, 0, 0);
    // R4 attention accumulate, clear on read, write ignored
    attn_set = 32'h8000_0011; @(negedge clk); attn_set = 32'h0000_0100; @(negedge clk);
    attn_set = '0; m_attn = 32'h8000_0111;
    access(1, 'h04, 2, 64'hFFFF_FFFF); access(0, 'h04, 2, 0); access(0, 'h04, 2, 0);
    attn_set = 32'h0000_0002;               // R4 set during the clearing read wins
    access(0, 'h04, 2, 0);
    attn_set = '0; m_attn = 32'h0000_0002;
    access(0, 'h04, 2, 0);
    // R5 control in-use on read, interrupt-disable keep/clear
    access(0, 'h80, 1, 0); access(0, 'h80, 1, 0);
    access(1, 'h80, 1, 64'h1234); access(0, 'h80, 1, 0);
    access(1, 'h80, 1, 64'h00F1); access(0, 'h80, 1, 0);
    // R1 channel windows are separate
    access(0, 'h100, 1, 0);
    access(0, 'h180, 1, 0); access(1, 'h190, 3, 64'h1);
    // R6 status, write ignored
    access(0, 'h88, 3, 0); access(0, 'h108, 3, 0);
    access(1, 'h108, 3, 64'hDEAD); access(0, 'h108, 3, 0);
    // R7 chain address halves on channel 1
    access(1, 'h110, 3, 64'h1111_2222_3333_4444);
    access(1, 'h110, 2, 64'hAAAA_AAAA_5555_6666); access(0, 'h110, 3, 0);
    access(1, 'h114, 2, 64'h0000_0000_7777_8888); access(0, 'h114, 2, 0);
    access(0, 'h110, 2, 0); access(0, 'h90, 3, 0);
    // R8 completion address halves on channel 0
    access(1, 'hA4, 2, 64'hCAFE_F00D); access(0, 'hA0, 3, 0);
    access(1, 'hA0, 2, 64'h0BAD_BEEF); access(0, 'hA0, 3, 0);
    access(1, 'hA0, 3, 64'h0123_4567_89AB_CDEF); access(0, 'hA4, 2, 0);
    // R9 command forwarding and zero readback
    access(1, 'h118, 0, 64'h5A); access(1, 'h98, 0, 64'hC3); access(0, 'h118, 0, 0);
    idle_cycle();
    // R10 write-1-to-clear with set priority
    chan_err_set[31:0] = 32'hF0F0; @(negedge clk); chan_err_set = '0; m_err[0] = 32'hF0F0;
    access(1, 'hA8, 2, 64'h00F0); access(0, 'hA8, 2, 0);
    chan_err_set[31:0] = 32'h1000;
    access(1, 'hA8, 2, 64'h1000);
    chan_err_set = '0; m_err[0] = m_err[0] | 32'h1000;
    access(0, 'hA8, 2, 0); access(0, 'h128, 2, 0);
    // R11 bad size / unmapped leave state untouched
    access(1, 'h110, 0, 64'hFFFF); access(1, 'h80, 2, 64'h1); access(1, 'hB0, 2, 64'h1);
    access(1, 'h118, 1, 64'h77); access(1, 'h03, 0, 64'h1);
    access(0, 'h110, 3, 0); access(0, 'h80, 1, 0); access(0, 'h02, 0, 0);
    idle_cycle();

    // near-exhaustive sweeps: every address, every size, writes then reads
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      for (int s = 0; s < 4; s++) begin
        access(1, a, s, {32'(a) * 32'h9E37_79B9, 32'(a * 4 + s) ^ 32'hC3A5_5A3C});
      end
    end
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      for (int s = 0; s < 4; s++) access(0, a, s, 0);
    end
    idle_cycle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule